// File: doc/BRIEF.md
# Splittable 64-bit Period Timer Core

This block is the counting core of a general-purpose timer. It holds two 32-bit counter halves. A mode input arranges them in one of three ways. In the first, the halves form a single 64-bit up-counter that is compared against a 64-bit period. In the second, the upper half is a prescaler that advances the lower half once each time it reaches its own period. In the third, the two halves run as independent timers, and the upper one is paced by a small reloadable prescale divider.

A counter that is preset above its period does not stop at the period. It counts on to the all-ones value of its width, wraps to zero, and then runs up to the period as usual. Each timer has an expiry output. When the timer reaches its period, the counter returns to zero on the next clock and the expiry output gives a one-cycle pulse. The pulse is presented twice: once as an interrupt request and once as an event strobe.

The surrounding logic drives the periods, the preset values, the enables and the per-half clears. The bus decoding, the register write protection, the capture storage and the interrupt routing all sit outside this block.

Top module: `split_period_timer`

## Requirements
- R1: After reset both counters read zero and all four expiry outputs are low.
- R2: With mode 2'b00 (wide) and `lo_en` high, the pair `{hi_cnt, lo_cnt}` advances by one per clock as one 64-bit value, and the carry passes from the lower half into the upper half.
- R3: In wide mode, when `{hi_cnt, lo_cnt}` equals `{hi_prd, lo_prd}` on an enabled cycle, both halves read zero after the next edge, and `lo_irq` and `lo_evt` are high for exactly that one cycle.
- R4: A counter preset above its period counts up to the all-ones value of its width (64-bit in wide mode, 32-bit in split mode), wraps to zero without an expiry pulse, and then expires at the period.
- R5: With mode 2'b01 (chained) and `lo_en` high, `hi_cnt` counts against `hi_prd` and returns to zero on a match. `lo_cnt` advances by one only on the cycle of that match and holds on every other cycle. `hi_irq` and `hi_evt` stay low.
- R6: In chained mode, a prescaler match while `lo_cnt` equals `lo_prd` returns `lo_cnt` to zero and pulses `lo_irq`/`lo_evt` for one cycle.
- R7: With mode 2'b10 (split) and `lo_en` high, `lo_cnt` counts against `lo_prd` on every clock, independent of the upper half, and expires through `lo_irq`/`lo_evt`.
- R8: In split mode with `hi_en` high, a down-counting prescaler gives one advance of `hi_cnt` each time it reaches zero, and then reloads from `psc_reload`. The upper counter therefore advances every `psc_reload`+1 clocks. The first advance after `hi_clr` comes on the first enabled clock.
- R9: In split mode, when an advance of the upper timer finds `hi_cnt` equal to `hi_prd`, the upper timer returns to zero and pulses `hi_irq`/`hi_evt` for one cycle. This pulse may fall in the same cycle as a lower-timer pulse.
- R10: `lo_clr` zeroes `lo_cnt`, and `hi_clr` zeroes `hi_cnt` and the prescaler, at the next edge. A clear wins over a load and over counting.
- R11: `lo_load`/`hi_load` place `lo_load_val`/`hi_load_val` in the matching counter at the next edge, taking priority over counting.
- R12: A timer whose enable is low holds its counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 wide, 01 chained, 10 split, 11 hold |
| lo_en | input | 1 | Enable for the lower timer (wide and chained modes run on this alone) |
| hi_en | input | 1 | Enable for the upper timer in split mode |
| lo_clr | input | 1 | Synchronous clear of the lower counter |
| hi_clr | input | 1 | Synchronous clear of the upper counter and the prescaler |
| lo_load | input | 1 | Load `lo_load_val` into the lower counter |
| hi_load | input | 1 | Load `hi_load_val` into the upper counter |
| lo_load_val | input | 32 | Preset for the lower counter |
| hi_load_val | input | 32 | Preset for the upper counter |
| lo_prd | input | 32 | Lower period word |
| hi_prd | input | 32 | Upper period word |
| psc_reload | input | 4 | Reload value of the split-mode prescaler |
| lo_cnt | output | 32 | Lower counter value |
| hi_cnt | output | 32 | Upper counter value |
| lo_irq | output | 1 | Lower/wide timer expiry interrupt pulse |
| lo_evt | output | 1 | Lower/wide timer expiry event pulse |
| hi_irq | output | 1 | Upper timer expiry interrupt pulse (split mode) |
| hi_evt | output | 1 | Upper timer expiry event pulse (split mode) |

## Verification
In split mode both timers can reach their periods on the same clock. The lower expiry comes from a plain count, while the upper one arrives through a prescaler tick. The bench chooses a lower period of 3, an upper period of 1 and a prescale reload of 2, so that the fourth enabled edge after a clear expires both timers. At that point it requires both counters to read zero with `lo_irq` and `hi_irq` high together, and both pulses to be gone one cycle later. A second overlap, a clear and a load arriving on the same cycle, is judged by the counter reading zero rather than the preset.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

   typedef enum logic [1:0] {
      TMODE_WIDE  = 2'b00,
      TMODE_CHAIN = 2'b01,
      TMODE_SPLIT = 2'b10,
      TMODE_HOLD  = 2'b11
   } tmode_e;

   typedef struct packed {
      logic step;
      logic zero;
      logic expire;
   } half_ctl_t;

endpackage

// File: rtl/tmr_half_cnt.sv
module tmr_half_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         zero,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         all_ones
);

   localparam logic [W-1:0] ONES = '1;

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr)       cnt_d = '0;
      else if (load) cnt_d = load_val;
      else if (zero) cnt_d = '0;
      else if (step) cnt_d = cnt_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt      = cnt_q;
   assign all_ones = (cnt_q == ONES);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W = 4,
   localparam int PW   = (PSC_W > 0) ? PSC_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [PW-1:0] reload,
   output logic          tick
);

   if (PSC_W == 0) begin : g_bypass
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, clr, reload};
      assign tick      = en;
   end else begin : g_divider
      logic [PSC_W-1:0] pcnt_q;
      logic             at_term;

      assign at_term = (pcnt_q == '0);
      assign tick    = en & at_term & ~clr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pcnt_q <= '0;
         else if (clr)     pcnt_q <= '0;
         else if (en) begin
            if (at_term)   pcnt_q <= reload;
            else           pcnt_q <= pcnt_q - PSC_W'(1);
         end
      end
   end

endmodule

// File: rtl/split_period_timer.sv
module split_period_timer
   import split_timer_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int PSC_W  = 4,
   localparam int WIDE_W = 2 * HALF_W,
   localparam int PSC_PW = (PSC_W > 0) ? PSC_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              lo_en,
   input  logic              hi_en,
   input  logic              lo_clr,
   input  logic              hi_clr,
   input  logic              lo_load,
   input  logic              hi_load,
   input  logic [HALF_W-1:0] lo_load_val,
   input  logic [HALF_W-1:0] hi_load_val,
   input  logic [HALF_W-1:0] lo_prd,
   input  logic [HALF_W-1:0] hi_prd,
   input  logic [PSC_PW-1:0] psc_reload,
   output logic [HALF_W-1:0] lo_cnt,
   output logic [HALF_W-1:0] hi_cnt,
   output logic              lo_irq,
   output logic              lo_evt,
   output logic              hi_irq,
   output logic              hi_evt
);

   if (HALF_W < 2) begin : g_bad_width
      $error("split_period_timer: HALF_W must be at least 2");
   end
   if (PSC_W > HALF_W) begin : g_bad_psc
      $error("split_period_timer: PSC_W must not exceed HALF_W");
   end

   tmode_e    cur_mode;
   half_ctl_t lo_ctl, hi_ctl;
   logic      lo_ones, hi_ones;
   logic      lo_match, hi_match, wide_match;
   logic      psc_en, psc_tick, chain_tick;
   logic      lo_exp_q, hi_exp_q;
   logic [WIDE_W-1:0] wide_cnt, wide_prd;

   assign cur_mode   = tmode_e'(mode);
   assign wide_cnt   = {hi_cnt, lo_cnt};
   assign wide_prd   = {hi_prd, lo_prd};
   assign lo_match   = (lo_cnt == lo_prd);
   assign hi_match   = (hi_cnt == hi_prd);
   assign wide_match = (wide_cnt == wide_prd);
   assign chain_tick = lo_en & hi_match;

   always_comb begin
      lo_ctl = '0;
      hi_ctl = '0;
      psc_en = 1'b0;
      unique case (cur_mode)
         TMODE_WIDE: begin
            lo_ctl.step   = lo_en;
            lo_ctl.zero   = lo_en & wide_match;
            lo_ctl.expire = lo_en & wide_match;
            hi_ctl.step   = lo_en & lo_ones;
            hi_ctl.zero   = lo_en & wide_match;
         end
         TMODE_CHAIN: begin
            hi_ctl.step   = lo_en;
            hi_ctl.zero   = chain_tick;
            lo_ctl.step   = chain_tick;
            lo_ctl.zero   = chain_tick & lo_match;
            lo_ctl.expire = chain_tick & lo_match;
         end
         TMODE_SPLIT: begin
            lo_ctl.step   = lo_en;
            lo_ctl.zero   = lo_en & lo_match;
            lo_ctl.expire = lo_en & lo_match;
            psc_en        = hi_en;
            hi_ctl.step   = psc_tick;
            hi_ctl.zero   = psc_tick & hi_match;
            hi_ctl.expire = psc_tick & hi_match;
         end
         default: begin
            lo_ctl = '0;
            hi_ctl = '0;
         end
      endcase
   end

   tmr_half_cnt #(.W(HALF_W)) u_lo_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (lo_clr),
      .load     (lo_load),
      .load_val (lo_load_val),
      .zero     (lo_ctl.zero),
      .step     (lo_ctl.step),
      .cnt      (lo_cnt),
      .all_ones (lo_ones)
   );

   tmr_half_cnt #(.W(HALF_W)) u_hi_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hi_clr),
      .load     (hi_load),
      .load_val (hi_load_val),
      .zero     (hi_ctl.zero),
      .step     (hi_ctl.step),
      .cnt      (hi_cnt),
      .all_ones (hi_ones)
   );

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hi_clr),
      .en     (psc_en),
      .reload (psc_reload),
      .tick   (psc_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_exp_q <= 1'b0;
         hi_exp_q <= 1'b0;
      end else begin
         lo_exp_q <= lo_ctl.expire & ~lo_clr & ~lo_load
                     & ~((cur_mode == TMODE_WIDE) & (hi_clr | hi_load));
         hi_exp_q <= hi_ctl.expire & ~hi_clr & ~hi_load;
      end
   end

   assign lo_irq = lo_exp_q;
   assign lo_evt = lo_exp_q;
   assign hi_irq = hi_exp_q;
   assign hi_evt = hi_exp_q;

   logic unused_hi_ones;
   assign unused_hi_ones = hi_ones;

endmodule

// File: rtl/split_period_timer_chk.sv
module split_period_timer_chk #(
   parameter int HALF_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              lo_en,
   input logic              hi_en,
   input logic              lo_clr,
   input logic              hi_clr,
   input logic              lo_load,
   input logic              hi_load,
   input logic [HALF_W-1:0] lo_prd,
   input logic [HALF_W-1:0] hi_prd,
   input logic [HALF_W-1:0] lo_cnt,
   input logic [HALF_W-1:0] hi_cnt,
   input logic              lo_irq,
   input logic              hi_irq
);

   AST_LO_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lo_irq |-> (lo_cnt == '0)); // R3

   AST_HI_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hi_irq |-> (hi_cnt == '0)); // R9

   AST_HI_QUIET_JOINED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b10) |=> (mode != 2'b10) |-> !hi_irq); // R5

   AST_LO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      lo_clr |=> (lo_cnt == '0)); // R10

   AST_HI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hi_clr |=> (hi_cnt == '0)); // R10

   AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && lo_en && !lo_clr && !lo_load && lo_cnt != lo_prd)
      |=> (lo_cnt == $past(lo_cnt) + 1'b1)); // R7

   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && hi_cnt != hi_prd && !lo_clr && !lo_load)
      |=> $stable(lo_cnt)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !lo_en && !lo_clr && !lo_load) |=> $stable(lo_cnt)); // R12

   logic unused_in;
   assign unused_in = &{1'b0, hi_en, hi_load};

endmodule

bind split_period_timer split_period_timer_chk #(.HALF_W(HALF_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode),
   .lo_en   (lo_en),
   .hi_en   (hi_en),
   .lo_clr  (lo_clr),
   .hi_clr  (hi_clr),
   .lo_load (lo_load),
   .hi_load (hi_load),
   .lo_prd  (lo_prd),
   .hi_prd  (hi_prd),
   .lo_cnt  (lo_cnt),
   .hi_cnt  (hi_cnt),
   .lo_irq  (lo_irq),
   .hi_irq  (hi_irq)
);

// File: tb/split_period_timer_tb_top.sv
module split_period_timer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        lo_en = 1'b0, hi_en = 1'b0;
   logic        lo_clr = 1'b0, hi_clr = 1'b0;
   logic        lo_load = 1'b0, hi_load = 1'b0;
   logic [31:0] lo_load_val = '0, hi_load_val = '0;
   logic [31:0] lo_prd = '0, hi_prd = '0;
   logic [3:0]  psc_reload = '0;
   logic [31:0] lo_cnt, hi_cnt;
   logic        lo_irq, lo_evt, hi_irq, hi_evt;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   split_period_timer dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .lo_en(lo_en), .hi_en(hi_en),
      .lo_clr(lo_clr), .hi_clr(hi_clr), .lo_load(lo_load), .hi_load(hi_load),
      .lo_load_val(lo_load_val), .hi_load_val(hi_load_val),
      .lo_prd(lo_prd), .hi_prd(hi_prd), .psc_reload(psc_reload),
      .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .lo_irq(lo_irq), .lo_evt(lo_evt),
      .hi_irq(hi_irq), .hi_evt(hi_evt)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_both();
      lo_clr = 1'b1; hi_clr = 1'b1;
      step(1);
      lo_clr = 1'b0; hi_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 lo_cnt", 64'(lo_cnt), 64'd0);
      check("R1 hi_cnt", 64'(hi_cnt), 64'd0);
      check("R1 pulses", 64'({lo_irq, lo_evt, hi_irq, hi_evt}), 64'd0);
   endtask

   task automatic t_wide();
      mode = 2'b00; hi_prd = 32'd1; lo_prd = 32'd2;
      lo_load_val = 32'hFFFF_FFFE; hi_load_val = 32'd0;
      lo_load = 1'b1; hi_load = 1'b1; step(1);
      lo_load = 1'b0; hi_load = 1'b0; lo_en = 1'b1;
      step(1);
      check("R2 wide pre-carry", {hi_cnt, lo_cnt}, 64'h0000_0000_FFFF_FFFF);
      step(1);
      check("R2 wide carry", {hi_cnt, lo_cnt}, 64'h0000_0001_0000_0000);
      step(2);
      check("R3 wide at period", {hi_cnt, lo_cnt}, 64'h0000_0001_0000_0002);
      check("R3 no early pulse", 64'(lo_irq), 64'd0);
      step(1);
      check("R3 wide zero", {hi_cnt, lo_cnt}, 64'd0);
      check("R3 pulses", 64'({lo_irq, lo_evt, hi_irq}), 64'b110);
      step(1);
      check("R3 pulse one cycle", 64'({lo_irq, lo_evt}), 64'd0);
      lo_en = 1'b0;
   endtask

   task automatic t_wide_roll();
      mode = 2'b00; hi_prd = 32'd0; lo_prd = 32'd5;
      lo_load_val = 32'hFFFF_FFFE; hi_load_val = 32'hFFFF_FFFF;
      lo_load = 1'b1; hi_load = 1'b1; step(1);
      lo_load = 1'b0; hi_load = 1'b0; lo_en = 1'b1;
      step(1);
      check("R4 wide all ones", {hi_cnt, lo_cnt}, 64'hFFFF_FFFF_FFFF_FFFF);
      step(1);
      check("R4 wide wrap", {hi_cnt, lo_cnt}, 64'd0);
      check("R4 wrap no pulse", 64'(lo_irq), 64'd0);
      step(6);
      check("R4 wide expires at period", 64'({lo_irq, lo_cnt == 32'd0}), 64'b11);
      lo_en = 1'b0;
   endtask

   task automatic t_chain();
      mode = 2'b01; hi_prd = 32'd2; lo_prd = 32'd1;
      clear_both();
      lo_en = 1'b1;
      step(2);
      check("R5 prescaler runs, lo holds", {hi_cnt, lo_cnt}, {32'd2, 32'd0});
      step(1);
      check("R5 lo advances on match", {hi_cnt, lo_cnt}, {32'd0, 32'd1});
      check("R5 hi pulse quiet", 64'({hi_irq, hi_evt, lo_irq}), 64'd0);
      step(2);
      check("R5 lo holds between", {hi_cnt, lo_cnt}, {32'd2, 32'd1});
      step(1);
      check("R6 chained expiry", {hi_cnt, lo_cnt}, 64'd0);
      check("R6 chained pulses", 64'({lo_irq, lo_evt, hi_irq}), 64'b110);
      step(1);
      check("R6 pulse ends", 64'(lo_irq), 64'd0);
      lo_en = 1'b0;
   endtask

   task automatic t_split();
      mode = 2'b10; lo_prd = 32'd3; hi_prd = 32'd1; psc_reload = 4'd2;
      clear_both();
      lo_en = 1'b1; hi_en = 1'b1;
      step(1);
      check("R8 first tick after clear", 64'(hi_cnt), 64'd1);
      check("R7 lo counts", 64'(lo_cnt), 64'd1);
      step(2);
      check("R8 hi held by prescaler", 64'(hi_cnt), 64'd1);
      check("R7 lo at period", 64'(lo_cnt), 64'd3);
      step(1);
      check("R9 both expire", {hi_cnt, lo_cnt}, 64'd0);
      check("R9 both pulses", 64'({lo_irq, lo_evt, hi_irq, hi_evt}), 64'hF);
      step(1);
      check("R9 pulses end", 64'({lo_irq, hi_irq}), 64'd0);
      check("R7 lo restarts", 64'(lo_cnt), 64'd1);
      lo_en = 1'b0;
      step(3);
      check("R12 lo holds", 64'(lo_cnt), 64'd1);
      check("R8 hi after reload interval", 64'(hi_cnt), 64'd1);
      hi_en = 1'b0;
      step(4);
      check("R12 hi holds", 64'(hi_cnt), 64'd1);
   endtask

   task automatic t_split_roll();
      mode = 2'b10; lo_prd = 32'd2;
      lo_load_val = 32'hFFFF_FFFE; lo_load = 1'b1; step(1);
      lo_load = 1'b0; lo_en = 1'b1;
      step(1);
      check("R4 32-bit all ones", 64'(lo_cnt), 64'hFFFF_FFFF);
      step(1);
      check("R4 32-bit wrap no pulse", 64'({lo_irq, lo_cnt}), 64'd0);
      step(3);
      check("R4 32-bit expires", 64'({lo_irq, lo_cnt}), 64'h1_0000_0000);
      lo_en = 1'b0;
   endtask

   task automatic t_priority();
      mode = 2'b10; lo_prd = 32'd100; lo_en = 1'b1;
      lo_load_val = 32'd7; lo_load = 1'b1; lo_clr = 1'b1;
      step(1);
      check("R10 clear beats load", 64'(lo_cnt), 64'd0);
      lo_clr = 1'b0;
      step(1);
      check("R11 load beats count", 64'(lo_cnt), 64'd7);
      lo_load = 1'b0; hi_load_val = 32'd9; hi_load = 1'b1; hi_en = 1'b1;
      step(1);
      check("R11 hi load", 64'(hi_cnt), 64'd9);
      hi_load = 1'b0; hi_clr = 1'b1;
      step(1);
      check("R10 hi clear", 64'(hi_cnt), 64'd0);
      hi_clr = 1'b0; lo_en = 1'b0; hi_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_wide();
      t_wide_roll();
      t_chain();
      t_split();
      t_split_roll();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule